// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block is a 32-line general-purpose I/O port. Software reaches it through a simple single-cycle register bus: a write strobe with byte address and data, and a read strobe whose result appears on the read-data bus one clock later. Through the registers, software chooses per line whether it drives, whether it drives as open-drain, and what value it drives. It can also read back line states, and it can arm per-line change events that are combined into one interrupt line.

Register bits are numbered in reverse: line n is held in register bit (31 - n), so line 0 sits in the most significant bit. On the pad side the three vectors (`pin_in`, `pin_out`, `pin_oe`) are indexed by line number. Incoming levels pass through a two-stage synchroniser. A change-detection stage then sets sticky event bits, either on falling edges only or on any edge, as selected per line. Software acknowledges events by writing ones.

Register map, with byte offsets and 32-bit registers: 0x00 direction, 0x04 open-drain, 0x08 data, 0x0C event, 0x10 mask, 0x14 edge control, 0x18 input buffer enable. All other offsets, including offsets that are not word aligned, are unmapped.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every register reads 0, `pin_oe` is all 0 and `irq` is 0.
- R2: Line n uses register bit (31 - n). A direction bit of 1 makes the line drive: `pin_oe[n]` is 1 and `pin_out[n]` equals data bit (31 - n). A direction bit of 0 keeps `pin_oe[n]` at 0. Pin outputs follow a register write by two clock edges.
- R3: When a line has both its direction bit and its open-drain bit set, `pin_oe[n]` is 1 only while its data bit is 0, and `pin_out[n]` is 0 whenever its open-drain bit is set.
- R4: Reading offset 0x08 returns the stored data bit for output lines. For input lines it returns the synchronised pin level when the line's input-buffer-enable bit (offset 0x18) is 1, and 0 when that bit is 0.
- R5: With edge control bit = 1, only a falling edge on the synchronised input sets the line's event bit.
- R6: With edge control bit = 0, both rising and falling edges set the line's event bit.
- R7: Writing offset 0x0C clears each event bit whose write-data bit is 1 and leaves bits written with 0 unchanged.
- R8: An edge detected in the same cycle as a clearing write to that bit leaves the event bit set.
- R9: `irq` is 1 one cycle after any bit of (event AND mask) is 1, and 0 one cycle after none is.
- R10: Reads of unmapped or unaligned offsets return 0, and writes to them change no register.
- R11: `bus_rdata` carries the addressed register's value in the cycle after the clock edge that samples `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pad input levels, indexed by line |
| pin_out | output | 32 | Pad output values, indexed by line |
| pin_oe | output | 32 | Pad drive enables, indexed by line |
| irq | output | 1 | Combined interrupt |

## Verification
A corrupted direction, open-drain or data bit shows on `pin_oe` or `pin_out` two edges after the write, and on a data readback one cycle after the read strobe. A wrongly set or lost event bit shows on `irq` one cycle after the mask bit is set, and in the event register on the next read. Because of the bit reversal, a mapping error moves the effect to the mirrored line, so the stimulus uses patterns that are not symmetric. The acknowledge-during-edge case is driven on the exact edge that loads the event bit.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Register select decoded from bus_addr[4:2]
  typedef enum logic [2:0] {
    SEL_DIR = 3'd0,
    SEL_ODR = 3'd1,
    SEL_DAT = 3'd2,
    SEL_EVT = 3'd3,
    SEL_MSK = 3'd4,
    SEL_CTL = 3'd5,
    SEL_IBE = 3'd6,
    SEL_NONE = 3'd7
  } reg_sel_e;

  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_in,    // line order
  input  logic [NPINS-1:0] edge_ctl,  // register order: 1 = falling only
  output logic [NPINS-1:0] lvl_r,     // register order, synchronised
  output logic [NPINS-1:0] hit_r      // register order, edge seen
);

  logic [NPINS-1:0] meta_q;
  logic [NPINS-1:0] sync_q;
  logic [NPINS-1:0] prev_q;

  for (genvar n = 0; n < NPINS; n++) begin : g_line
    localparam int unsigned RB = NPINS - 1 - n;

    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q[RB] <= 1'b0;
        sync_q[RB] <= 1'b0;
        prev_q[RB] <= 1'b0;
      end else begin
        meta_q[RB] <= pin_in[n];
        sync_q[RB] <= meta_q[RB];
        prev_q[RB] <= sync_q[RB];
      end
    end

    always_comb begin
      if (edge_ctl[RB]) hit_r[RB] = prev_q[RB] & ~sync_q[RB];
      else              hit_r[RB] = prev_q[RB] ^ sync_q[RB];
    end
  end

  assign lvl_r = sync_q;

  // Falling-only lines never report a rising edge
  AST_FALL_ONLY: assert property (@(posedge clk) disable iff (rst)
    ((hit_r & edge_ctl) & sync_q) == '0); // R5

endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] hit,
  input  logic [NPINS-1:0] clr,
  output logic [NPINS-1:0] evt
);

  logic [NPINS-1:0] evt_q;

  always_ff @(posedge clk) begin
    if (rst) evt_q <= '0;
    else     evt_q <= (evt_q & ~clr) | hit;
  end

  assign evt = evt_q;

  AST_EVT_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
    ((evt_q & ~$past(evt_q)) & ~$past(hit)) == '0); // R6

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
    ($past(hit) & ~evt_q) == '0); // R8

  AST_CLR_ONLY_ONES: assert property (@(posedge clk) disable iff (rst)
    (($past(evt_q) & ~evt_q) & ~$past(clr)) == '0); // R7

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] dir_r,  // register order
  input  logic [NPINS-1:0] od_r,
  input  logic [NPINS-1:0] dat_r,
  output logic [NPINS-1:0] pin_out, // line order
  output logic [NPINS-1:0] pin_oe
);

  logic [NPINS-1:0] out_q;
  logic [NPINS-1:0] oe_q;

  for (genvar n = 0; n < NPINS; n++) begin : g_drv
    localparam int unsigned RB = NPINS - 1 - n;
    always_ff @(posedge clk) begin
      if (rst) begin
        out_q[n] <= 1'b0;
        oe_q[n]  <= 1'b0;
      end else begin
        out_q[n] <= dat_r[RB] & ~od_r[RB];
        oe_q[n]  <= dir_r[RB] & ~(od_r[RB] & dat_r[RB]);
      end
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = oe_q;

  function automatic logic [NPINS-1:0] flip(input logic [NPINS-1:0] v);
    for (int i = 0; i < NPINS; i++) flip[i] = v[NPINS-1-i];
  endfunction

  AST_IN_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (pin_oe & ~flip($past(dir_r))) == '0); // R2

  AST_OD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (pin_oe & flip($past(od_r & dat_r))) == '0); // R3

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);

  logic [NPINS-1:0] dir_q, od_q, dat_q, msk_q, ctl_q, ibe_q;
  logic [NPINS-1:0] evt, lvl_r, hit_r, evt_clr, dat_view, rd_mux;
  logic [NPINS-1:0] rdata_q;
  logic             irq_q;
  reg_sel_e         sel;

  // Address decode: aligned offsets 0x00..0x18 only
  always_comb begin
    if (bus_addr[1:0] != 2'b00) sel = SEL_NONE;
    else                        sel = reg_sel_e'(bus_addr[ADDR_W-1:2]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0; od_q <= '0; dat_q <= '0;
      msk_q <= '0; ctl_q <= '0; ibe_q <= '0;
    end else if (bus_wr) begin
      unique case (sel)
        SEL_DIR: dir_q <= bus_wdata;
        SEL_ODR: od_q  <= bus_wdata;
        SEL_DAT: dat_q <= bus_wdata;
        SEL_MSK: msk_q <= bus_wdata;
        SEL_CTL: ctl_q <= bus_wdata;
        SEL_IBE: ibe_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign evt_clr = (bus_wr && sel == SEL_EVT) ? bus_wdata : '0;

  gpio_in_sync #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rst(rst), .pin_in(pin_in), .edge_ctl(ctl_q),
    .lvl_r(lvl_r), .hit_r(hit_r)
  );

  gpio_evt_bank #(.NPINS(NPINS)) u_evt (
    .clk(clk), .rst(rst), .hit(hit_r), .clr(evt_clr), .evt(evt)
  );

  gpio_pin_drive #(.NPINS(NPINS)) u_drv (
    .clk(clk), .rst(rst), .dir_r(dir_q), .od_r(od_q), .dat_r(dat_q),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // Outputs read their latch; inputs read the pad through the buffer gate
  assign dat_view = (dir_q & dat_q) | (~dir_q & ibe_q & lvl_r);

  always_comb begin
    unique case (sel)
      SEL_DIR: rd_mux = dir_q;
      SEL_ODR: rd_mux = od_q;
      SEL_DAT: rd_mux = dat_view;
      SEL_EVT: rd_mux = evt;
      SEL_MSK: rd_mux = msk_q;
      SEL_CTL: rd_mux = ctl_q;
      SEL_IBE: rd_mux = ibe_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (bus_rd) rdata_q <= rd_mux;
      irq_q <= |(evt & msk_q);
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(evt & msk_q))); // R9

  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_rd) && $past(sel) == SEL_NONE) |-> (bus_rdata == '0)); // R10

  AST_IN_GATED: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_rd) && $past(sel) == SEL_DAT) |->
      ((bus_rdata & ~$past(dir_q) & ~$past(ibe_q)) == '0)); // R4

endmodule

// File: tb/gpio_port_ctrl_bench.sv
module gpio_port_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, pin_in = '0;
  logic [31:0] bus_rdata, pin_out, pin_oe;
  logic        irq;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk; // 250 MHz

  gpio_port_ctrl u_gpio_port_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // Stimulus vectors: {dir, od, data, ibe, pin_in}
  localparam logic [159:0] VEC [4] = '{
    {32'hFFFF0000, 32'h00000000, 32'hA5A55A5A, 32'hFFFFFFFF, 32'h0F0F0F0F},
    {32'h0000FFFF, 32'h0000FF00, 32'h12345678, 32'hFF00FF00, 32'hFFFFFFFF},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 32'hF0F0F0F0, 32'h00000000, 32'h00000000},
    {32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0F0F0F0F, 32'h3C3C3C3C}
  };

  function automatic logic [31:0] rev(input logic [31:0] v);
    for (int i = 0; i < 32; i++) rev[i] = v[31-i];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 7; a++) begin
      rd(5'(a * 4), v); chk("R1 reg", v, 32'h0);
    end
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R2 R3 R4 R11: vector table
    for (int k = 0; k < 4; k++) begin
      logic [31:0] d_dir, d_od, d_dat, d_ibe, d_pin;
      {d_dir, d_od, d_dat, d_ibe, d_pin} = VEC[k];
      wr(5'h00, d_dir); wr(5'h04, d_od); wr(5'h08, d_dat); wr(5'h18, d_ibe);
      @(negedge clk); pin_in = d_pin;
      settle();
      chk("R2 R3 pin_oe", pin_oe, rev(d_dir & ~(d_od & d_dat)));
      chk("R2 R3 pin_out", pin_out, rev(d_dat & ~d_od));
      rd(5'h08, v);
      chk("R4 R11 data read", v, (d_dir & d_dat) | (~d_dir & d_ibe & rev(d_pin)));
    end

    // R10: unmapped and unaligned offsets
    wr(5'h00, 32'h00C0FFEE);
    wr(5'h1C, 32'hFFFFFFFF);
    wr(5'h01, 32'hFFFFFFFF);
    rd(5'h1C, v); chk("R10 unmapped read", v, 32'h0);
    rd(5'h05, v); chk("R10 unaligned read", v, 32'h0);
    rd(5'h00, v); chk("R10 dir untouched", v, 32'h00C0FFEE);

    // Quiet state for events
    @(negedge clk); pin_in = '0;
    wr(5'h00, 32'h0); wr(5'h04, 32'h0); wr(5'h18, 32'h0); wr(5'h10, 32'h0);
    settle();
    wr(5'h0C, 32'hFFFFFFFF);
    rd(5'h0C, v); chk("R7 clear all", v, 32'h0);

    // Line 3 falling-only (bit 28), line 4 any edge (bit 27)
    wr(5'h14, 32'h10000000);
    @(negedge clk); pin_in = 32'h00000018;
    settle();
    rd(5'h0C, v); chk("R5 R6 rising", v, 32'h08000000);
    @(negedge clk); pin_in = 32'h0;
    settle();
    rd(5'h0C, v); chk("R5 R6 falling", v, 32'h18000000);

    // R7: acknowledge one bit, other untouched
    wr(5'h0C, 32'h08000000);
    rd(5'h0C, v); chk("R7 w1c", v, 32'h10000000);

    // R9: interrupt follows mask and event
    wr(5'h10, 32'h10000000);
    settle();
    chk("R9 irq on", {31'h0, irq}, 32'h1);
    wr(5'h10, 32'h08000000);
    settle();
    chk("R9 irq masked", {31'h0, irq}, 32'h0);
    wr(5'h0C, 32'h10000000);
    wr(5'h10, 32'h10000000);
    settle();
    chk("R9 irq after clear", {31'h0, irq}, 32'h0);

    // R8: edge landing on the clearing edge (line 5 any edge, bit 26)
    @(negedge clk); pin_in = 32'h00000020;
    settle();
    rd(5'h0C, v); chk("R8 pre-set", v, 32'h04000000);
    @(negedge clk); pin_in = 32'h0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 5'h0C; bus_wdata = 32'h04000000;
    @(negedge clk); bus_wr = 1'b0;
    rd(5'h0C, v); chk("R8 edge beats clear", v, 32'h04000000);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule